// File: doc/BRIEF.md
# GPIO Unit with Pin Interrupts

This block is a memory-mapped general-purpose I/O unit with 32 pins. It is reached over a simple 16-bit register port: a byte address, a write strobe, write data and a combinational read path. Each pin has an output latch, an output-enable path and a synchronized input. A 2-bit field per pin chooses between input and output, and between plain GPIO and an alternate function.

The lower 16 pins can also raise interrupts. Each of these pins has a 2-bit trigger code that selects high level, low level, rising edge or falling edge. Trigger hits on these pins land in a sticky status register that software clears by writing ones to it. A status bit reaches the interrupt line only when its enable bit is set and its mask bit is clear. The interrupt output is registered.

The intended use is a CPU-side driver. It configures the mode and trigger fields, clears stale status, clears the pin's mask bit and sets its enable bit. When the line fires, it reads the status register and acknowledges the bits it serviced.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every data, mode, trigger, status and enable bit reads 0, all 16 mask bits read 1 (byte 0x12 reads 0xFFFF), and irq_o, pin_o and pin_oe_o are all low.
- R2: Pin n lives in the data register at byte 0x00 (n < 16) or 0x02 (n >= 16), at bit n mod 16. A write sets the output latch that drives pin_o, and pin_o changes only on such a write. A read returns the latch bit for a pin whose output is enabled, and otherwise the pin input delayed by two clock stages.
- R3: The 2-bit mode field of pin n is in the register at byte 0x04 + 2*(n>>3), at bit offset (n mod 8)*2. Field bit 0 set means output and field bit 1 set means alternate function. pin_oe_o[n] is high only for the code "output, GPIO" (01), and the field reads back as written.
- R4: The 2-bit trigger codes for pins 8..15 sit in the register at byte 0x0C, and those for pins 0..7 sit at byte 0x0E, each at bit offset (pin mod 8)*2. The codes are 00 high level, 01 low level, 10 rising edge and 11 falling edge, and both registers read back as written.
- R5: With an edge code, the pin's status bit (byte 0x10, bit = pin) is set three clock edges after the input changes in the chosen direction. It stays set after the input returns, until software clears it.
- R6: With a level code, the status bit is set again on every clock while the level holds, so a clear does not stick while the level persists.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a trigger hit and a clear of the same bit fall in one cycle, the bit ends up set.
- R8: irq_o equals, one cycle later, the OR over pins 0..15 of status AND enable (byte 0x14) AND NOT mask (byte 0x12). A set mask bit blocks the pin.
- R9: Pins 16..31 never set a status bit or affect irq_o.
- R10: Reads of unmapped addresses (0x16..0x1E) return 0, and writes there change no register.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the halfword register (bit 0 ignored) |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output latch values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can meet on the same clock edge: a trigger hit that sets a status bit, and a software write-one-to-clear aimed at that same bit. The bench counts the synchronizer stages to place the clear strobe exactly on the edge where a rising input first sets status. It expects the bit to stay set (hit wins), and reads the status register afterwards to confirm it. A low-level pin being cleared while its level persists exercises the same collision from the level side. A cycle-level reference model compares irq_o, the pin outputs and the read data on every clock, so any one-cycle error in ordering shows up at once.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int unsigned MODE_OUT_BIT = 0;
  localparam int unsigned MODE_ALT_BIT = 1;
  localparam int unsigned FIELD_W      = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         cur_i,
  input  logic [N-1:0]         prev_i,
  input  logic [FIELD_W*N-1:0] trig_i,
  output logic [N-1:0]         hit_o
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    trig_e code;
    assign code = trig_e'(trig_i[FIELD_W*i +: FIELD_W]);
    always_comb begin
      unique case (code)
        TRIG_HIGH: hit_o[i] = cur_i[i];
        TRIG_LOW:  hit_o[i] = ~cur_i[i];
        TRIG_RISE: hit_o[i] = cur_i[i] & ~prev_i[i];
        TRIG_FALL: hit_o[i] = ~cur_i[i] & prev_i[i];
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);

  logic [N-1:0] status_q;
  logic         irq_q;

  // hit wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | hit_i;
      irq_q    <= |(status_q & en_i & ~mask_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned NIRQ = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe_o,
  output logic            irq_o
);

  localparam int unsigned FPR      = DW / FIELD_W;   // fields per register
  localparam int unsigned NDATA    = NPIN / DW;
  localparam int unsigned NMODE    = NPIN / FPR;
  localparam int unsigned NTRIG    = NIRQ / FPR;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_MODE = IDX_DATA + NDATA;
  localparam int unsigned IDX_TRIG = IDX_MODE + NMODE;
  localparam int unsigned IDX_STAT = IDX_TRIG + NTRIG;
  localparam int unsigned IDX_MASK = IDX_STAT + 1;
  localparam int unsigned IDX_EN   = IDX_MASK + 1;

  logic [AW-2:0]           wr_idx;
  logic                    unused_addr;
  logic [NPIN-1:0]         data_q;
  logic [FIELD_W*NPIN-1:0] mode_q;
  logic [FIELD_W*NIRQ-1:0] trig_q;   // indexed by pin
  logic [NIRQ-1:0]         mask_q, en_q, status_q, hit, clr;
  logic [NPIN-1:0]         sync_cur, sync_prev, oe, rd_pin;

  assign wr_idx      = addr_i[AW-1:1];
  assign unused_addr = addr_i[0];

  // ---------------- register writes ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mode_q <= '0;
      trig_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NDATA; k++)
        if (int'(wr_idx) == IDX_DATA + k) data_q[k*DW +: DW] <= wdata_i;
      for (int k = 0; k < NMODE; k++)
        if (int'(wr_idx) == IDX_MODE + k) mode_q[k*DW +: DW] <= wdata_i;
      // trigger registers hold pin groups in reverse order
      for (int k = 0; k < NTRIG; k++)
        if (int'(wr_idx) == IDX_TRIG + k) trig_q[(NTRIG-1-k)*DW +: DW] <= wdata_i;
      if (int'(wr_idx) == IDX_MASK) mask_q <= wdata_i[NIRQ-1:0];
      if (int'(wr_idx) == IDX_EN)   en_q   <= wdata_i[NIRQ-1:0];
    end
  end

  assign clr = (we_i && int'(wr_idx) == IDX_STAT) ? wdata_i[NIRQ-1:0] : '0;

  // ---------------- pin path ----------------
  for (genvar p = 0; p < NPIN; p++) begin : g_oe
    assign oe[p] = mode_q[FIELD_W*p + MODE_OUT_BIT] & ~mode_q[FIELD_W*p + MODE_ALT_BIT];
  end

  assign pin_o    = data_q;
  assign pin_oe_o = oe;
  assign rd_pin   = (oe & data_q) | (~oe & sync_cur);

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  logic unused_prev_hi;
  if (NPIN > NIRQ) begin : g_unused
    assign unused_prev_hi = ^sync_prev[NPIN-1:NIRQ];
  end else begin : g_nounused
    assign unused_prev_hi = 1'b0;
  end

  gpio_trig_det #(.N(NIRQ)) u_det (
    .cur_i  (sync_cur[NIRQ-1:0]),
    .prev_i (sync_prev[NIRQ-1:0]),
    .trig_i (trig_q),
    .hit_o  (hit)
  );

  gpio_irq_agg #(.N(NIRQ)) u_agg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (clr),
    .en_i     (en_q),
    .mask_i   (mask_q),
    .status_o (status_q),
    .irq_o    (irq_o)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NDATA; k++)
      if (int'(wr_idx) == IDX_DATA + k) rdata_o = rd_pin[k*DW +: DW];
    for (int k = 0; k < NMODE; k++)
      if (int'(wr_idx) == IDX_MODE + k) rdata_o = mode_q[k*DW +: DW];
    for (int k = 0; k < NTRIG; k++)
      if (int'(wr_idx) == IDX_TRIG + k) rdata_o = trig_q[(NTRIG-1-k)*DW +: DW];
    if (int'(wr_idx) == IDX_STAT) rdata_o[NIRQ-1:0] = status_q;
    if (int'(wr_idx) == IDX_MASK) rdata_o[NIRQ-1:0] = mask_q;
    if (int'(wr_idx) == IDX_EN)   rdata_o[NIRQ-1:0] = en_q;
  end

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int unsigned NPIN = 32,
  parameter int unsigned NIRQ = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [NPIN-1:0]   pin_o,
  input logic              irq_o,
  input logic [NIRQ-1:0]   status_q,
  input logic [NIRQ-1:0]   mask_q,
  input logic [NIRQ-1:0]   en_q,
  input logic [2*NIRQ-1:0] trig_q,
  input logic [NIRQ-1:0]   sync_cur,
  input logic [NIRQ-1:0]   sync_prev
);

  localparam int unsigned FPR      = DW / 2;
  localparam int unsigned NDATA    = NPIN / DW;
  localparam int unsigned IDX_STAT = NDATA + NPIN / FPR + NIRQ / FPR;

  logic [AW-2:0] idx;
  logic          stat_wr, data_wr, unused_a0;

  assign idx       = addr_i[AW-1:1];
  assign unused_a0 = addr_i[0];
  assign stat_wr   = we_i && int'(idx) == IDX_STAT;
  assign data_wr   = we_i && int'(idx) < NDATA;

  assert_pin_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr |=> $stable(pin_o));

  assert_mask_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |=> !irq_o);

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & en_q & ~mask_q) == '0) |=> !irq_o);

  assert_irq_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & en_q & ~mask_q) != '0) |=> irq_o);

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    assert_edge_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && trig_q[2*i+1] && !(stat_wr && wdata_i[i])) |=> status_q[i]);

    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr && wdata_i[i] && trig_q[2*i+1] && (sync_cur[i] == sync_prev[i]))
      |=> !status_q[i]);

    assert_level_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_q[2*i+1] && (sync_cur[i] == ~trig_q[2*i])) |=> status_q[i]);
  end

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .NPIN(NPIN), .NIRQ(NIRQ), .DW(DW), .AW(AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pin_o     (pin_o),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .en_q      (en_q),
  .trig_q    (trig_q),
  .sync_cur  (sync_cur[NIRQ-1:0]),
  .sync_prev (sync_prev[NIRQ-1:0])
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_o, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_data, m_trig, s1, s2, pv;
  logic [63:0] m_mode;
  logic [15:0] m_st, m_mask, m_en, m_hit, m_clr;
  logic        m_irq;

  function automatic logic [31:0] m_oe();
    logic [31:0] v;
    for (int p = 0; p < 32; p++) v[p] = (m_mode[2*p +: 2] == 2'b01);
    return v;
  endfunction

  function automatic logic [15:0] m_read(input logic [4:0] a);
    logic [31:0] live;
    live = (m_oe() & m_data) | (~m_oe() & s2);
    case (a[4:1])
      4'd0: return live[15:0];
      4'd1: return live[31:16];
      4'd2: return m_mode[15:0];
      4'd3: return m_mode[31:16];
      4'd4: return m_mode[47:32];
      4'd5: return m_mode[63:48];
      4'd6: return m_trig[31:16];
      4'd7: return m_trig[15:0];
      4'd8: return m_st;
      4'd9: return m_mask;
      4'd10: return m_en;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_mode = '0; m_trig = '0; m_st = '0; m_mask = '1; m_en = '0;
      m_irq = 1'b0; s1 = '0; s2 = '0; pv = '0;
    end else begin
      for (int p = 0; p < 16; p++) begin
        if (m_trig[2*p +: 2] == 2'd0)      m_hit[p] = s2[p];
        else if (m_trig[2*p +: 2] == 2'd1) m_hit[p] = !s2[p];
        else if (m_trig[2*p +: 2] == 2'd2) m_hit[p] = s2[p] && !pv[p];
        else                               m_hit[p] = !s2[p] && pv[p];
      end
      m_clr = (we && addr[4:1] == 4'd8) ? wdata : 16'h0;
      m_irq = |(m_st & m_en & ~m_mask);
      m_st  = (m_st & ~m_clr) | m_hit;
      pv = s2; s2 = s1; s1 = pins;
      if (we) begin
        case (addr[4:1])
          4'd0: m_data[15:0]  = wdata;
          4'd1: m_data[31:16] = wdata;
          4'd2: m_mode[15:0]  = wdata;
          4'd3: m_mode[31:16] = wdata;
          4'd4: m_mode[47:32] = wdata;
          4'd5: m_mode[63:48] = wdata;
          4'd6: m_trig[31:16] = wdata;
          4'd7: m_trig[15:0]  = wdata;
          4'd9: m_mask = wdata;
          4'd10: m_en  = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(irq === m_irq, "R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk(pin_o === m_data, "R2 pin_o vs model", pin_o, m_data);
      chk(pin_oe === m_oe(), "R3 pin_oe vs model", pin_oe, m_oe());
      chk(rdata === m_read(addr), "R10 rdata vs model", {16'b0, rdata},
          {16'b0, m_read(addr)});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); we = 1'b0; addr = a;
    #3 chk(rdata === exp, req, {16'b0, rdata}, {16'b0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(5'h12, 16'hFFFF, "R1 mask reset");
    rd(5'h10, 16'h0000, "R1 status reset");
    rd(5'h14, 16'h0000, "R1 enable reset");
    chk(irq === 1'b0 && pin_oe === '0 && pin_o === '0, "R1 outputs low",
        {irq, pin_oe[30:0]}, 32'h0);

    // R3 mode fields, R2 output latch
    wr(5'h04, 16'h0001);
    wr(5'h00, 16'h0001);
    #3 chk(pin_o[0] === 1'b1 && pin_oe[0] === 1'b1, "R3 pin0 driven",
           {30'b0, pin_o[0], pin_oe[0]}, 32'h3);
    wr(5'h0A, 16'h4000);
    #3 chk(pin_oe[31] === 1'b1, "R3 pin31 output", {31'b0, pin_oe[31]}, 32'h1);
    wr(5'h0A, 16'hC000);
    #3 chk(pin_oe[31] === 1'b0, "R3 pin31 alt releases", {31'b0, pin_oe[31]}, 32'h0);
    rd(5'h0A, 16'hC000, "R3 mode readback");

    // R2 input read and R9 upper pin has no interrupt effect
    @(negedge clk); pins[20] = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'h02, 16'h0010, "R2 input pin20 read");
    rd(5'h00, 16'h0001, "R2 output latch read");
    rd(5'h10, 16'h0000, "R9 upper pin no status");

    // R4 trigger fields, swapped halves
    wr(5'h0E, 16'h0008);
    wr(5'h0C, 16'h0003);
    rd(5'h0E, 16'h0008, "R4 low-group trig readback");
    rd(5'h0C, 16'h0003, "R4 high-group trig readback");

    // R5 rising edge on pin1
    @(negedge clk); pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'h10, 16'h0002, "R5 rising sets status");
    @(negedge clk); pins[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'h10, 16'h0002, "R5 status sticky");

    // R8 falling edge on pin8 (code 11)
    @(negedge clk); pins[8] = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); pins[8] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'h10, 16'h0102, "R4 falling code on pin8");

    // R7 write-one-to-clear
    wr(5'h10, 16'hFEFD);
    rd(5'h10, 16'h0102, "R7 zero bits keep status");
    wr(5'h10, 16'h0102);
    rd(5'h10, 16'h0000, "R7 one bits clear status");

    // R7 hit and clear in the same cycle
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    wr(5'h10, 16'h0002);
    rd(5'h10, 16'h0002, "R7 hit wins over clear");
    @(negedge clk); pins[1] = 1'b0;

    // R8 aggregation
    wr(5'h14, 16'h0002);
    @(negedge clk);
    #3 chk(irq === 1'b0, "R8 masked pin blocked", {31'b0, irq}, 32'h0);
    wr(5'h12, 16'hFFFD);
    @(negedge clk);
    #3 chk(irq === 1'b1, "R8 unmasked pin fires", {31'b0, irq}, 32'h1);
    wr(5'h12, 16'hFFFF);
    @(negedge clk);
    #3 chk(irq === 1'b0, "R8 mask drops irq", {31'b0, irq}, 32'h0);
    wr(5'h12, 16'hFFFD);
    wr(5'h10, 16'h0002);
    @(negedge clk);
    #3 chk(irq === 1'b0, "R8 clear drops irq", {31'b0, irq}, 32'h0);

    // R6 low level on pin3 keeps reasserting
    wr(5'h0E, 16'h0048);
    repeat (3) @(negedge clk);
    rd(5'h10, 16'h0008, "R6 low level sets");
    wr(5'h10, 16'h0008);
    rd(5'h10, 16'h0008, "R6 level reasserts after clear");
    @(negedge clk); pins[3] = 1'b1;
    repeat (4) @(negedge clk);
    wr(5'h10, 16'h0008);
    rd(5'h10, 16'h0000, "R6 clear sticks once level gone");

    // R9 toggle upper pins with interrupts enabled
    wr(5'h14, 16'hFFFF);
    wr(5'h12, 16'h0000);
    @(negedge clk); pins[31:16] = 16'hFFFF;
    repeat (4) @(negedge clk);
    @(negedge clk); pins[31:16] = 16'h0000;
    repeat (4) @(negedge clk);
    rd(5'h10, 16'h0000, "R9 upper pins no status");
    #1 chk(irq === 1'b0, "R9 upper pins no irq", {31'b0, irq}, 32'h0);

    // R10 unmapped space
    rd(5'h1E, 16'h0000, "R10 unmapped read zero");
    wr(5'h16, 16'h1234);
    rd(5'h16, 16'h0000, "R10 unmapped write ignored");
    rd(5'h14, 16'hFFFF, "R10 enable untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule